// File: doc/BRIEF.md
# Cache Identification Register Bank

This block is a small bank of system-control registers. Software reads it to learn the shape of the cache hierarchy. One register is writable: a cache-size selector. It picks which per-level cache size descriptor an indirect read returns. The other registers are read-only constants:

- a table of size descriptors, one per cache level and type;
- a level-identification word;
- a cache-type word.

Each access is addressed by three selector fields (`op1`, `crm`, `op2`). An access that names no implemented register is flagged as undefined.

A request is presented with `req_valid`. The block never applies back-pressure: `req_ready` is held high once reset is released, so a request is taken on every cycle in which `req_valid` is high. Exactly one cycle after a request is taken, `rsp_valid` pulses for one cycle. In that cycle `rsp_rdata` and `rsp_undef` carry the result. The response path has no ready signal, so the consumer must take every response in the cycle it appears.

The parameter `NEW_ARCH` selects between two behaviours:

- When it is 1, the selector is writable and the indirect descriptor read is live.
- When it is 0, the selector write is refused and the level and descriptor reads all return zero.

Top module: `cid_bank`

## Requirements
- R1: After reset, `rsp_valid` is low and the selector holds 0. A selector read issued first therefore returns 0 with `rsp_undef` low.
- R2: With `NEW_ARCH`=1, a write with op1=2, crm=0, op2=0 stores `req_wdata[3:0]` in the selector and answers with `rsp_undef` low. A later selector read returns that value, zero-extended to 32 bits.
- R3: With `NEW_ARCH`=0, the selector write is answered with `rsp_undef` high and leaves the selector unchanged.
- R4: With `NEW_ARCH`=1, a read with op1=1, crm=0, op2=0 returns the descriptor picked by the selector:
  - selector 0 gives 0xE007E01A (16 KB level-1 data cache);
  - selector 1 gives 0x2007E01A (16 KB level-1 instruction cache);
  - selector 2 gives 0xF0000000 (no level-2 instruction cache);
  - selector values 3 to 15 give 0.
- R5: With `NEW_ARCH`=1, a read with op1=1, crm=0, op2=1 returns the level-identification word 0x0A000003, which is (1<<27)|(2<<24)|3.
- R6: With `NEW_ARCH`=1, a read with op1=1, crm=0, op2=7 returns 0 with `rsp_undef` low. Any other op2 under op1=1, and any op1=1 read with crm not 0, is undefined.
- R7: With `NEW_ARCH`=0, every op1=1 read with crm=0 returns 0 with `rsp_undef` low, whatever op2 is.
- R8: A read with op1=2 returns the selector only when op2=0 and crm=0. Every other op1=2 read is undefined.
- R9: A read with op1=0, crm=0, op2=1 returns the cache-type word 0x82048004. The following are undefined and never change the selector:
  - any other read with op1=0;
  - any read with op1 from 3 to 7;
  - every write other than the selector write.
- R10: `rsp_valid` is high exactly in the cycle after each accepted request. `req_ready` is high whenever reset is released. An undefined access, and every write, returns `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (high out of reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op1 | input | 3 | Primary selector field |
| req_crm | input | 4 | Secondary register field |
| req_op2 | input | 3 | Sub-selector field |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_undef | output | 1 | Access names no implemented register |

## Verification
The bench goes after the following corner cases, and after what a wrong design would do on each:

- **Selector width and upper bits.** It writes selector values whose upper data bits are set. A design that stored too many bits would read back garbage. A design that ignored bits would read back the wrong descriptor.
- **Selector values past the table.** It steps the selector beyond the last descriptor. A design that wrapped the index, or returned stale data there, would show a non-zero word where zero is required.
- **Legacy configuration.** A second instance, built with the newer behaviour off, must refuse the selector write and return zeros for op1=1. A design that leaked descriptors, or stored the write anyway, would be caught there.
- **Neighbouring encodings.** It probes op2 and crm values next to each valid encoding. A loose decoder would answer where it must flag undefined.

// File: rtl/cid_pkg.sv
package cid_pkg;

  localparam logic [31:0] CTYPE_WORD = 32'h8204_8004;
  localparam logic [31:0] LEVEL_WORD = (32'd1 << 27) | (32'd2 << 24) | 32'd3;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_DESC,
    SRC_LEVEL,
    SRC_SEL,
    SRC_CTYPE
  } src_e;

  function automatic logic [31:0] desc_value(input int idx);
    case (idx)
      0:       return 32'hE007_E01A;
      1:       return 32'h2007_E01A;
      2:       return 32'hF000_0000;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/cid_decode.sv
module cid_decode
  import cid_pkg::*;
#(
  parameter bit NEW_ARCH = 1'b1
) (
  input  logic       write,
  input  logic [2:0] op1,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       sel_wr,
  output src_e       src,
  output logic       undef
);
  logic crm_zero;
  assign crm_zero = (crm == 4'd0);

  always_comb begin
    sel_wr = 1'b0;
    src    = SRC_ZERO;
    undef  = 1'b1;
    if (write) begin
      if (NEW_ARCH && op1 == 3'd2 && crm_zero && op2 == 3'd0) begin
        sel_wr = 1'b1;
        undef  = 1'b0;
      end
    end else begin
      case (op1)
        3'd0: if (crm_zero && op2 == 3'd1) begin
          src   = SRC_CTYPE;
          undef = 1'b0;
        end
        3'd1: if (crm_zero) begin
          if (!NEW_ARCH) begin
            undef = 1'b0;
          end else begin
            case (op2)
              3'd0: begin src = SRC_DESC;  undef = 1'b0; end
              3'd1: begin src = SRC_LEVEL; undef = 1'b0; end
              3'd7: begin src = SRC_ZERO;  undef = 1'b0; end
              default: undef = 1'b1;
            endcase
          end
        end
        3'd2: if (crm_zero && op2 == 3'd0) begin
          src   = SRC_SEL;
          undef = 1'b0;
        end
        default: undef = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cid_desc_table.sv
module cid_desc_table
  import cid_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int NUM_DESC = 3
) (
  input  logic [SEL_W-1:0] sel,
  output logic [31:0]      desc
);
  localparam int DEPTH = 1 << SEL_W;

  logic [31:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    if (i < NUM_DESC) begin : g_impl
      assign table_q[i] = desc_value(i);
    end else begin : g_empty
      assign table_q[i] = 32'd0;
    end
  end

  assign desc = table_q[sel];
endmodule

// File: rtl/cid_sel_reg.sv
module cid_sel_reg #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_val,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wr_val;
  end
endmodule

// File: rtl/cid_bank.sv
module cid_bank
  import cid_pkg::*;
#(
  parameter bit NEW_ARCH = 1'b1,
  parameter int SEL_W    = 4,
  parameter int NUM_DESC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_undef
);
  localparam int PAD_W = 32 - SEL_W;

  logic             dec_sel_wr;
  src_e             dec_src;
  logic             dec_undef;
  logic [SEL_W-1:0] sel_q;
  logic [31:0]      desc_word;
  logic [31:0]      rd_word;

  cid_decode #(.NEW_ARCH(NEW_ARCH)) u_dec (
    .write (req_write),
    .op1   (req_op1),
    .crm   (req_crm),
    .op2   (req_op2),
    .sel_wr(dec_sel_wr),
    .src   (dec_src),
    .undef (dec_undef)
  );

  cid_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (req_valid && dec_sel_wr),
    .wr_val(req_wdata[SEL_W-1:0]),
    .sel_q (sel_q)
  );

  cid_desc_table #(.SEL_W(SEL_W), .NUM_DESC(NUM_DESC)) u_tab (
    .sel (sel_q),
    .desc(desc_word)
  );

  always_comb begin
    case (dec_src)
      SRC_DESC:  rd_word = desc_word;
      SRC_LEVEL: rd_word = LEVEL_WORD;
      SRC_SEL:   rd_word = {{PAD_W{1'b0}}, sel_q};
      SRC_CTYPE: rd_word = CTYPE_WORD;
      default:   rd_word = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
      rsp_undef <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write && !dec_undef) ? rd_word : 32'd0;
      rsp_undef <= req_valid && dec_undef;
    end
  end

  assign req_ready = rst_n;
endmodule

// File: rtl/cid_bank_chk.sv
module cid_bank_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [2:0]       req_op1,
  input logic [3:0]       req_crm,
  input logic [2:0]       req_op2,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_undef,
  input logic [SEL_W-1:0] sel_q
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R10
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready); // R10
  AST_UNDEF_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_undef) |-> rsp_rdata == 32'd0); // R10
  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == 32'd0); // R10
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(sel_q)); // R9
  AST_SEL_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_op1 == 3'd2 && req_op2 == 3'd0 && req_crm == 4'd0)
      |=> (!rsp_undef && rsp_rdata[31:SEL_W] == '0)); // R8
  AST_HIGH_OP1_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_op1 > 3'd2) |=> rsp_undef); // R9
endmodule

bind cid_bank cid_bank_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_op1(req_op1), .req_crm(req_crm), .req_op2(req_op2),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .sel_q(sel_q)
);

// File: tb/cid_bank_test.sv
module cid_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_op1 = '0;
  logic [3:0]  req_crm = '0;
  logic [2:0]  req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic        n_ready, n_valid, n_undef, o_ready, o_valid, o_undef;
  logic [31:0] n_rdata, o_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] m_sel_new = 4'd0;
  logic [3:0] m_sel_old = 4'd0;

  always #2 clk = ~clk;

  cid_bank #(.NEW_ARCH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(n_ready),
    .req_write(req_write), .req_op1(req_op1), .req_crm(req_crm), .req_op2(req_op2),
    .req_wdata(req_wdata), .rsp_valid(n_valid), .rsp_rdata(n_rdata), .rsp_undef(n_undef));

  cid_bank #(.NEW_ARCH(1'b0)) uut_legacy (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(o_ready),
    .req_write(req_write), .req_op1(req_op1), .req_crm(req_crm), .req_op2(req_op2),
    .req_wdata(req_wdata), .rsp_valid(o_valid), .rsp_rdata(o_rdata), .rsp_undef(o_undef));

  function automatic logic [31:0] exp_desc(input logic [3:0] s);
    case (s)
      4'd0:    return 32'hE007E01A;
      4'd1:    return 32'h2007E01A;
      4'd2:    return 32'hF0000000;
      default: return 32'h0;
    endcase
  endfunction

  // returns {undef, data}
  function automatic logic [32:0] model(input bit na, input bit wr, input logic [2:0] o1,
                                        input logic [3:0] cm, input logic [2:0] o2,
                                        input logic [3:0] s);
    if (wr) return {!(na && o1 == 2 && cm == 0 && o2 == 0), 32'h0};
    if (o1 == 0 && cm == 0 && o2 == 1) return {1'b0, 32'h82048004};
    if (o1 == 1 && cm == 0) begin
      if (!na) return {1'b0, 32'h0};
      if (o2 == 0) return {1'b0, exp_desc(s)};
      if (o2 == 1) return {1'b0, 32'h0A000003};
      if (o2 == 7) return {1'b0, 32'h0};
      return {1'b1, 32'h0};
    end
    if (o1 == 2 && cm == 0 && o2 == 0) return {1'b0, 28'h0, s};
    return {1'b1, 32'h0};
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got undef=%0b data=%08h expected undef=%0b data=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic op(input string req, input bit wr, input logic [2:0] o1, input logic [3:0] cm,
                    input logic [2:0] o2, input logic [31:0] wd);
    logic [32:0] en, eo;
    en = model(1'b1, wr, o1, cm, o2, m_sel_new);
    eo = model(1'b0, wr, o1, cm, o2, m_sel_old);
    req_valid = 1'b1; req_write = wr; req_op1 = o1; req_crm = cm; req_op2 = o2; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {32'h0, n_valid & o_valid}, 33'h1);
    check({req, " new"}, {n_undef, n_rdata}, en);
    check({req, " legacy"}, {o_undef, o_rdata}, eo);
    if (wr && !en[32]) m_sel_new = wd[3:0];
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got running expected finished");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid idle", {32'h0, n_valid | o_valid}, 33'h0);
    check("R10 ready", {32'h0, n_ready & o_ready}, 33'h1);
    op("R1 selector after reset", 1'b0, 3'd2, 4'd0, 3'd0, 32'h0);
    op("R4 desc idx0", 1'b0, 3'd1, 4'd0, 3'd0, 32'h0);
    op("R2 write sel 1 with upper bits", 1'b1, 3'd2, 4'd0, 3'd0, 32'hFFFF_FFF1);
    op("R2 readback", 1'b0, 3'd2, 4'd0, 3'd0, 32'h0);
    op("R4 desc idx1", 1'b0, 3'd1, 4'd0, 3'd0, 32'h0);
    op("R3 legacy write refused", 1'b1, 3'd2, 4'd0, 3'd0, 32'h2);
    op("R4 desc idx2", 1'b0, 3'd1, 4'd0, 3'd0, 32'h0);
    for (int s = 3; s < 16; s++) begin
      op("R2 write high sel", 1'b1, 3'd2, 4'd0, 3'd0, s);
      op("R4 desc past table", 1'b0, 3'd1, 4'd0, 3'd0, 32'h0);
    end
    op("R5 level word", 1'b0, 3'd1, 4'd0, 3'd1, 32'h0);
    op("R6 op2=7 zero", 1'b0, 3'd1, 4'd0, 3'd7, 32'h0);
    op("R6 op2=3 undef", 1'b0, 3'd1, 4'd0, 3'd3, 32'h0);
    op("R6 crm nonzero undef", 1'b0, 3'd1, 4'd5, 3'd0, 32'h0);
    op("R7 legacy op2=2", 1'b0, 3'd1, 4'd0, 3'd2, 32'h0);
    op("R8 op2 nonzero undef", 1'b0, 3'd2, 4'd0, 3'd1, 32'h0);
    op("R8 crm nonzero undef", 1'b0, 3'd2, 4'd1, 3'd0, 32'h0);
    op("R9 cache type", 1'b0, 3'd0, 4'd0, 3'd1, 32'h0);
    op("R9 op1=0 other undef", 1'b0, 3'd0, 4'd0, 3'd0, 32'h0);
    op("R9 op1=5 undef", 1'b0, 3'd5, 4'd0, 3'd0, 32'h0);
    op("R9 bad write", 1'b1, 3'd2, 4'd0, 3'd1, 32'h1);
    op("R9 sel unchanged", 1'b0, 3'd2, 4'd0, 3'd0, 32'h0);
    @(negedge clk);
    check("R10 no response when idle", {32'h0, n_valid | o_valid}, 33'h0);
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o1, o2;
      logic [3:0] cm;
      bit wr;
      o1 = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3);
      cm = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
      o2 = ($urandom % 2 == 0) ? 3'($urandom % 2) : 3'($urandom);
      wr = ($urandom % 3 == 0);
      op("R4 R10 random", wr, o1, cm, o2, $urandom);
      if ($urandom % 4 == 0) @(negedge clk);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule